// File: doc/BRIEF.md
# Sleep clock enable delay sequencer

This block drives the active-low sleep-clock enable of a power management unit. Software programs a 32-bit control register over a simple register bus. The register holds an enable bit and a 30-bit delay. When the active-low suspend-acknowledge input falls and the enable bit is set, the block counts the programmed number of edges of a slow timing clock. It then drives the sleep-clock enable low.

Release has no delay. A high level on the wakeup input forces the output high through combinational logic, without waiting for any clock edge. Clearing the enable bit also releases the output at once. Suspend-acknowledge and wakeup pass through synchronizers before they reach the counting logic in the timing-clock domain. The direct wakeup path to the output bypasses those synchronizers. When suspend-acknowledge is withdrawn, the counter and the output clear, and the next suspend assertion starts a fresh count.

Top module: `slpclk_seq`

## Requirements
- R1: While reset is applied and just after it ends, the control register reads 00000000h and `sleep_clk_en_n` is high.
- R2: A bus write at offset 10h stores all 32 bits, and a read there returns them unchanged, including reserved bit 31. Reads at any other offset return zero, and writes there leave the control register unchanged.
- R3: Bit 30 of the control register is the enable and bits 29:0 are the delay N. With the enable set, `sleep_clk_en_n` falls exactly SYNC_STAGES+1+N rising timing-clock edges after `suspack_n` falls, and stays high before that.
- R4: With a delay of zero, the output falls on the first timing-clock edge after the synchronized suspend-acknowledge is seen, which is edge SYNC_STAGES+1.
- R5: With bit 30 low, `sleep_clk_en_n` never falls, whatever the delay and however long suspend-acknowledge is held.
- R6: A high `wake` forces `sleep_clk_en_n` high combinationally, in the same instant and without any clock edge.
- R7: Once asserted, the output stays low until a wakeup arrives or suspend-acknowledge is withdrawn. Withdrawal releases it SYNC_STAGES+1 timing-clock edges after `suspack_n` rises.
- R8: A wakeup during the count aborts the count. The output does not assert again while suspend-acknowledge stays held. The next falling edge of `suspack_n` restarts the full count from zero.
- R9: Writing the enable bit low while the output is asserted releases it immediately after that bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte offset for the read and write access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tclk | input | 1 | Slow timing clock used to count the delay |
| suspack_n | input | 1 | Suspend acknowledge, active low |
| wake | input | 1 | Wakeup event, active high |
| sleep_clk_en_n | output | 1 | Sleep-clock enable, active low |

## Verification
A wakeup and a timed assertion can fall in the same cycle: the counter reaches its limit on an edge while `wake` is already high. The bench raises `wake` a few edges before the count would end and holds it across the expected assert edge. It requires the output to stay high throughout, and to stay high after `wake` drops while suspend-acknowledge is still held. A second coincidence is a wakeup that arrives between clock edges while the output is low. The bench changes `wake` away from both clocks and samples the output a fraction of a nanosecond later, so only a combinational path can pass.

// File: rtl/slpclk_pkg.sv
package slpclk_pkg;

  localparam int unsigned CTRL_W = 32;
  localparam int unsigned DLY_W  = 30;

  typedef struct packed {
    logic             rsvd;
    logic             en;
    logic [DLY_W-1:0] delay;
  } ctrl_reg_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_ASSERT = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/slpclk_sync.sv
module slpclk_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d;
      end else begin : g_rest
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/slpclk_regs.sv
module slpclk_regs
  import slpclk_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output ctrl_reg_t         ctrl
);

  ctrl_reg_t ctrl_q;
  ctrl_reg_t ctrl_d;
  logic      hit;
  logic      ctrl_we;

  assign hit     = (addr == CTRL_OFF);
  assign ctrl_we = wr & hit;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_reg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  assign rdata = hit ? CTRL_W'(ctrl_q) : '0;
  assign ctrl  = ctrl_q;

  // R2: a write at the control offset is held exactly, reserved bit included
  a_r2_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CTRL_OFF) |=> (CTRL_W'(ctrl_q) == $past(wdata)));

  // R2: accesses elsewhere leave the control register alone
  a_r2_other_offset: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == CTRL_OFF) |=> $stable(ctrl_q));

endmodule

// File: rtl/slpclk_delay.sv
module slpclk_delay
  import slpclk_pkg::*;
(
  input  logic             tclk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             susp_i,
  input  logic             wake_i,
  output logic             asserted_o
);

  seq_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DLY_W:0]   cnt_inc;
  logic             cnt_en;
  logic             abort;
  logic             start;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign abort   = wake_i | ~susp_i | ~en_i;
  assign start   = susp_i & en_i & ~wake_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cnt_en  = 1'b1;
          cnt_d   = '0;
          state_d = (delay_i == '0) ? ST_ASSERT : ST_COUNT;
        end
      end
      ST_COUNT: begin
        cnt_en = 1'b1;
        if (abort) begin
          cnt_d   = '0;
          state_d = ST_HOLD;
        end else if (cnt_inc >= {1'b0, delay_i}) begin
          state_d = ST_ASSERT;
        end else begin
          cnt_d = cnt_inc[DLY_W-1:0];
        end
      end
      ST_ASSERT: begin
        if (abort) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (!susp_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign asserted_o = (state_q == ST_ASSERT);

  // R5: the assert state is only entered with the enable set
  a_r5_entry_needs_en: assert property (@(posedge tclk) disable iff (!rst_n)
    (state_q == ST_ASSERT && $past(state_q) != ST_ASSERT) |-> $past(en_i));

  // R8: every count starts from zero
  a_r8_count_from_zero: assert property (@(posedge tclk) disable iff (!rst_n)
    (state_q == ST_COUNT && $past(state_q) == ST_IDLE) |-> (cnt_q == '0));

  // R8: wakeup or withdrawal during count or assert parks the sequencer
  a_r8_abort_parks: assert property (@(posedge tclk) disable iff (!rst_n)
    ((state_q == ST_COUNT || state_q == ST_ASSERT) && (wake_i || !susp_i))
      |=> (state_q == ST_HOLD));

  // R8: a parked sequencer waits for suspend withdrawal before counting again
  a_r8_hold_no_restart: assert property (@(posedge tclk) disable iff (!rst_n)
    (state_q == ST_HOLD && susp_i) |=> (state_q == ST_HOLD));

endmodule

// File: rtl/slpclk_seq.sv
module slpclk_seq
  import slpclk_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF    = 8'h10,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tclk,
  input  logic              suspack_n,
  input  logic              wake,
  output logic              sleep_clk_en_n
);

  logic      rst_bus_n;
  logic      rst_t_n;
  logic      susp_s;
  logic      wake_s;
  logic      asserted;
  ctrl_reg_t ctrl;

  slpclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_bus (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_bus_n)
  );

  slpclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_t (
    .clk(tclk), .rst_n(rst_n), .d(1'b1), .q(rst_t_n)
  );

  slpclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_susp (
    .clk(tclk), .rst_n(rst_t_n), .d(~suspack_n), .q(susp_s)
  );

  slpclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wake (
    .clk(tclk), .rst_n(rst_t_n), .d(wake), .q(wake_s)
  );

  slpclk_regs #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) u_regs (
    .clk(clk), .rst_n(rst_bus_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ctrl(ctrl)
  );

  // configuration is quasi-static: software changes it only while idle
  slpclk_delay u_delay (
    .tclk(tclk), .rst_n(rst_t_n), .en_i(ctrl.en), .delay_i(ctrl.delay),
    .susp_i(susp_s), .wake_i(wake_s), .asserted_o(asserted)
  );

  // release path: raw wakeup and enable gate the registered assert
  assign sleep_clk_en_n = ~(asserted & ctrl.en & ~wake);

  // R6: wakeup holds the output released
  a_r6_wake_releases: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> sleep_clk_en_n);

  // R5: no assertion with the enable clear
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> sleep_clk_en_n);

  // R1: released while the timing domain is in reset
  a_r1_reset_released: assert property (@(posedge clk)
    !rst_t_n |-> sleep_clk_en_n);

endmodule

// File: tb/slpclk_seq_tb.sv
`timescale 1ns/10ps
module slpclk_seq_tb;

  localparam int SYNC = 2;
  localparam logic [7:0] CTRL_OFF = 8'h10;

  logic        clk = 1'b0;
  logic        tclk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        suspack_n;
  logic        wake;
  logic        sleep_clk_en_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  always #20  tclk = ~tclk;

  slpclk_seq #(.ADDR_W(8), .CTRL_OFF(CTRL_OFF), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tclk(tclk),
    .suspack_n(suspack_n), .wake(wake), .sleep_clk_en_n(sleep_clk_en_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic tedges(input int n);
    for (int k = 0; k < n; k++) @(posedge tclk);
    @(negedge tclk);
  endtask

  task automatic release_susp();
    @(negedge tclk);
    suspack_n = 1'b1;
    wake = 1'b0;
    tedges(SYNC + 3);
  endtask

  // drop suspack_n and check the exact assert edge
  task automatic timed_assert(input int n, input string req);
    bit early = 1'b0;
    @(negedge tclk);
    suspack_n = 1'b0;
    for (int k = 0; k < SYNC + n; k++) begin
      @(posedge tclk);
      @(negedge tclk);
      if (!sleep_clk_en_n) early = 1'b1;
    end
    check(!early, req, $sformatf("held high before edge, delay %0d", n),
          {31'd0, early}, 32'd0);
    @(posedge tclk);
    #1;
    check(sleep_clk_en_n == 1'b0, req, $sformatf("asserted at edge, delay %0d", n),
          {31'd0, sleep_clk_en_n}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    bus_addr = CTRL_OFF;
    #1;
    check(bus_rdata == 32'h0, "R1", "register during reset", bus_rdata, 32'h0);
    check(sleep_clk_en_n == 1'b1, "R1", "output during reset", {31'd0, sleep_clk_en_n}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    tedges(4);
    bus_read(CTRL_OFF, r);
    check(r == 32'h0, "R1", "register after reset", r, 32'h0);
    check(sleep_clk_en_n == 1'b1, "R1", "output after reset", {31'd0, sleep_clk_en_n}, 32'd1);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    bus_write(CTRL_OFF, 32'hC000_0005);
    bus_read(CTRL_OFF, r);
    check(r == 32'hC000_0005, "R2", "readback with reserved bit", r, 32'hC000_0005);
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_read(8'h14, r);
    check(r == 32'h0, "R2", "other offset reads zero", r, 32'h0);
    bus_read(CTRL_OFF, r);
    check(r == 32'hC000_0005, "R2", "other offset write ignored", r, 32'hC000_0005);
    bus_write(CTRL_OFF, 32'h0);
  endtask

  task automatic t_delays();
    bus_write(CTRL_OFF, 32'h4000_0000);
    timed_assert(0, "R4");
    release_susp();
    bus_write(CTRL_OFF, 32'h4000_0001);
    timed_assert(1, "R3");
    release_susp();
    bus_write(CTRL_OFF, 32'h4000_0005);
    timed_assert(5, "R3");
    release_susp();
    bus_write(CTRL_OFF, 32'hC000_0025);
    timed_assert(37, "R3");
    release_susp();
  endtask

  task automatic t_disabled();
    bit seen = 1'b0;
    bus_write(CTRL_OFF, 32'h0000_0003);
    @(negedge tclk);
    suspack_n = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge tclk);
      if (!sleep_clk_en_n) seen = 1'b1;
    end
    check(!seen, "R5", "enable clear never asserts", {31'd0, seen}, 32'd0);
    release_susp();
  endtask

  task automatic t_hold_and_release();
    bit lost = 1'b0;
    bus_write(CTRL_OFF, 32'h4000_0002);
    timed_assert(2, "R3");
    for (int k = 0; k < 10; k++) begin
      @(negedge tclk);
      if (sleep_clk_en_n) lost = 1'b1;
    end
    check(!lost, "R7", "stays asserted while held", {31'd0, lost}, 32'd0);
    @(negedge tclk);
    suspack_n = 1'b1;
    for (int k = 0; k < SYNC; k++) @(posedge tclk);
    #1;
    check(sleep_clk_en_n == 1'b0, "R7", "still low before withdrawal seen",
          {31'd0, sleep_clk_en_n}, 32'd0);
    @(posedge tclk);
    #1;
    check(sleep_clk_en_n == 1'b1, "R7", "released after withdrawal",
          {31'd0, sleep_clk_en_n}, 32'd1);
    tedges(3);
  endtask

  task automatic t_wake_comb();
    bus_write(CTRL_OFF, 32'h4000_0000);
    timed_assert(0, "R4");
    @(posedge clk);
    #1.0;
    wake = 1'b1;
    #0.2;
    check(sleep_clk_en_n == 1'b1, "R6", "combinational wake release",
          {31'd0, sleep_clk_en_n}, 32'd1);
    release_susp();
  endtask

  task automatic t_wake_midcount();
    bit seen = 1'b0;
    bus_write(CTRL_OFF, 32'h4000_0014);
    @(negedge tclk);
    suspack_n = 1'b0;
    tedges(SYNC + 1 + 5);
    wake = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge tclk);
      if (!sleep_clk_en_n) seen = 1'b1;
    end
    wake = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge tclk);
      if (!sleep_clk_en_n) seen = 1'b1;
    end
    check(!seen, "R8", "aborted count stays released", {31'd0, seen}, 32'd0);
    release_susp();
    timed_assert(20, "R8");
    release_susp();
  endtask

  task automatic t_enable_clear();
    bus_write(CTRL_OFF, 32'h4000_0000);
    timed_assert(0, "R4");
    bus_write(CTRL_OFF, 32'h0000_0000);
    #0.5;
    check(sleep_clk_en_n == 1'b1, "R9", "enable clear releases",
          {31'd0, sleep_clk_en_n}, 32'd1);
    release_susp();
  endtask

  initial begin
    rst_n = 1'b0;
    bus_wr = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    suspack_n = 1'b1;
    wake = 1'b0;
    #50;
    t_reset();
    t_regs();
    t_delays();
    t_disabled();
    t_hold_and_release();
    t_wake_comb();
    t_wake_midcount();
    t_enable_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule